// File: doc/BRIEF.md
# Receive Status Sticky Interrupt Register

This block gathers the per-frame status events of an Ethernet receive path into one 32-bit accumulating status word. Each event arrives as a single-cycle pulse on its own line. The pulse sets a matching sticky bit, and that bit stays set until software reads the word. A companion mask register decides which latched bits may drive the level interrupt line. Masked events are still recorded, but they do not raise the interrupt.

A read strobe returns the whole word on the same cycle and clears every bit at the clock edge that ends the access. No event is lost to a read. An event that coincides with a clearing read is set again right after the clear. Only the low `NUM_EVT` bit positions carry status. The reserved upper positions always read as zero.

The interrupt is registered. It is the OR of all latched bits that are not masked, sampled one cycle late. It stays high as long as such bits remain set.

Top module: `rxs_status_irq`

## Requirements
- R1: After reset (`rst_n` low), every status bit is 0, `irq_o` is 0 and every mask bit is 0 (all sources enabled), whatever the state before reset.
- R2: A pulse on `evt_i[i]` sets status bit i at the next rising edge. The bit then holds at 1 across later edges until a read clears it.
- R3: A mask bit value of 1 suppresses its source. An event on a masked position still sets its status bit, but while only masked bits are set `irq_o` stays 0.
- R4: `irq_o` is 1 on the cycle after the status word holds at least one set bit whose mask bit is 0. It remains 1 for as long as such a bit remains set.
- R5: While `rd_en_i` is high, `rd_data_o` shows the current status word. The rising edge that ends that cycle clears every status bit, and `irq_o` falls one edge later.
- R6: An event pulse in the same cycle as a clearing read leaves its status bit set after that edge. Other bits are cleared.
- R7: Bits 31 down to `NUM_EVT` (31:15 by default) of `rd_data_o` are always 0.
- R8: A mask write (`mask_we_i` high) loads `mask_wdata_i` at the rising edge. Masking pending bits drops `irq_o`, and unmasking latched bits raises it, one edge after the new mask takes effect.
- R9: Pulses on several event lines in one cycle, up to all of them, all latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Per-bit single-cycle receive status event pulses |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | NUM_EVT | New mask value, 1 = source masked |
| rd_en_i | input | 1 | Read strobe; clears the status word at the edge |
| rd_data_o | output | DATA_W | Status word, upper reserved bits zero |
| irq_o | output | 1 | Level interrupt from unmasked latched bits |

## Verification
The bench targets an event landing on the same cycle as a clearing read. A design that orders set before clear would drop that event silently and the next read would come back empty. It also fills the word with only masked bits and then flips the mask both ways. A design that gates latching with the mask, or that computes the interrupt from raw events, would show a missing status bit or a wrong interrupt level. A mid-run reset over a non-zero mask and status word exposes a mask register left out of the reset. Reads of an all-set word show whether any reserved bit leaks.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // Next value of one sticky status bit: a clear wipes the old value,
  // an event set in the same cycle wins over the clear.
  function automatic logic sticky_bit(input logic cur, input logic set, input logic clr);
    return (cur & ~clr) | set;
  endfunction

  // One bit contributes to the interrupt when latched and not masked.
  function automatic logic pend_bit(input logic stat, input logic mask);
    return stat & ~mask;
  endfunction

endpackage

// File: rtl/rxs_mask_reg.sv
module rxs_mask_reg #(
  parameter int NUM_EVT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] mask_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end

  // R8: a write lands at the edge
  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_o == $past(wdata_i)));

  a_r8_mask_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_o));

endmodule

// File: rtl/rxs_sticky_bank.sv
module rxs_sticky_bank #(
  parameter int NUM_EVT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_i,
  output logic [NUM_EVT-1:0] stat_o
);

  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] stat_d;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    assign stat_d[i] = rxs_pkg::sticky_bit(stat_q[i], evt_i[i], clr_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= stat_d[i];
    end
  end

  assign stat_o = stat_q;

  // R2: without a clear no set bit is lost
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R2 / R9: every pulsed bit is set after the edge
  a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

  // R5: a clear with no event empties the word
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (evt_i == '0)) |=> (stat_q == '0));

  // R6: a clear keeps exactly the coinciding events
  a_r6_survive: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stat_q == $past(evt_i)));

endmodule

// File: rtl/rxs_irq_gen.sv
module rxs_irq_gen #(
  parameter int NUM_EVT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] stat_i,
  input  logic [NUM_EVT-1:0] mask_i,
  output logic               irq_o
);

  logic [NUM_EVT-1:0] pend_vec;
  logic               pend_any;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_pend
    assign pend_vec[i] = rxs_pkg::pend_bit(stat_i[i], mask_i[i]);
  end

  assign pend_any = |pend_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend_any;
  end

  // R4: an unmasked latched bit raises the line one cycle later
  a_r4_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_i & ~mask_i) != '0) |=> irq_o);

  // R3: only masked (or no) bits set keeps the line low
  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_i & ~mask_i) == '0) |=> !irq_o);

endmodule

// File: rtl/rxs_status_irq.sv
module rxs_status_irq #(
  parameter int NUM_EVT = 15,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               mask_we_i,
  input  logic [NUM_EVT-1:0] mask_wdata_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               irq_o
);

  localparam int RSV_W = DATA_W - NUM_EVT;

  logic [NUM_EVT-1:0] stat_w;
  logic [NUM_EVT-1:0] mask_w;
  logic               clr_evt;

  assign clr_evt = rd_en_i;

  rxs_mask_reg #(.NUM_EVT(NUM_EVT)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_w)
  );

  rxs_sticky_bank #(.NUM_EVT(NUM_EVT)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (clr_evt),
    .stat_o (stat_w)
  );

  rxs_irq_gen #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_w),
    .mask_i (mask_w),
    .irq_o  (irq_o)
  );

  assign rd_data_o = {{RSV_W{1'b0}}, stat_w};

  // R5: a read with no coinciding event ends the interrupt two edges on
  a_r5_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && (evt_i == '0)) |=> ##1 !irq_o);

  // R2: the visible word only loses bits through a read
  a_r2_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> ((rd_data_o & $past(rd_data_o)) == $past(rd_data_o)));

endmodule

// File: tb/rxs_status_irq_tb_top.sv
`timescale 1ns/1ps
module rxs_status_irq_tb_top;

  localparam int N     = 15;
  localparam int DW    = 32;
  localparam int NSTEP = 21;

  // Stimulus / expectation table, one row per clock step.
  // EXP_IRQ is irq_o sampled after the step's edge.
  localparam logic [N-1:0] T_EVT [NSTEP] = '{
    15'h0001, 15'h0000, 15'h0000, 15'h0000, 15'h0004, 15'h0000, 15'h0000,
    15'h4000, 15'h0000, 15'h0010, 15'h0000, 15'h0000, 15'h0000, 15'h0000,
    15'h0000, 15'h0000, 15'h0000, 15'h7FFF, 15'h0000, 15'h0000, 15'h0000};
  localparam logic T_MWE [NSTEP] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [N-1:0] T_MVAL [NSTEP] = '{
    15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0004, 15'h0000, 15'h0000,
    15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0010, 15'h0000, 15'h0000,
    15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000, 15'h0000};
  localparam logic T_RD [NSTEP] = '{
    1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [DW-1:0] T_EXP_RD [NSTEP] = '{
    32'h0, 32'h0, 32'h0001, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0, 32'h4004, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h0010, 32'h0, 32'h0, 32'h7FFF, 32'h0, 32'h0};
  localparam logic T_EXP_IRQ [NSTEP] = '{
    1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1,
    1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt = '0;
  logic          mask_we = 1'b0;
  logic [N-1:0]  mask_wdata = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  rxs_status_irq #(.NUM_EVT(N), .DATA_W(DW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .mask_we_i    (mask_we),
    .mask_wdata_i (mask_wdata),
    .rd_en_i      (rd_en),
    .rd_data_o    (rd_data),
    .irq_o        (irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    evt = '0; mask_we = 1'b0; mask_wdata = '0; rd_en = 1'b0;
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input logic [N-1:0] e, input logic we, input logic [N-1:0] mv,
                      input logic rd);
    evt = e; mask_we = we; mask_wdata = mv; rd_en = rd;
    #1;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset status", rd_data, '0);
    check("R1 reset irq", {31'b0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", rd_data, '0);

    // Table walk: R2 R3 R4 R5 R6 R8 R9
    for (int k = 0; k < NSTEP; k++) begin
      evt = T_EVT[k]; mask_we = T_MWE[k]; mask_wdata = T_MVAL[k]; rd_en = T_RD[k];
      #1;
      if (T_RD[k]) check($sformatf("R5 R6 table read step %0d", k), rd_data, T_EXP_RD[k]);
      @(negedge clk);
      idle_inputs();
      check($sformatf("R2 R3 R4 R8 table irq step %0d", k), {31'b0, irq}, {31'b0, T_EXP_IRQ[k]});
    end

    // R6: event coinciding with read survives, others cleared
    step(15'h0003, 1'b0, '0, 1'b0);
    evt = 15'h0100; rd_en = 1'b1;
    #1;
    check("R6 read before clear", rd_data, 32'h0003);
    @(negedge clk);
    idle_inputs();
    check("R6 survivor only", rd_data, 32'h0100);
    step('0, 1'b0, '0, 1'b1);
    check("R6 cleared", rd_data, '0);

    // R2: bit held across many idle cycles
    step(15'h2000, 1'b0, '0, 1'b0);
    repeat (5) step('0, 1'b0, '0, 1'b0);
    check("R2 sticky hold", rd_data, 32'h2000);
    check("R4 irq held", {31'b0, irq}, 32'h1);

    // R3: masked-only word keeps irq low, unmask raises it
    step('0, 1'b0, '0, 1'b1);
    step(15'h0200, 1'b1, 15'h0200, 1'b0);
    step('0, 1'b0, '0, 1'b0);
    step('0, 1'b0, '0, 1'b0);
    check("R3 masked bit latched", rd_data, 32'h0200);
    check("R3 masked irq low", {31'b0, irq}, '0);
    step('0, 1'b1, 15'h0000, 1'b0);
    check("R8 unmask not yet", {31'b0, irq}, '0);
    step('0, 1'b0, '0, 1'b0);
    check("R8 unmask raises irq", {31'b0, irq}, 32'h1);

    // R7 / R9: all lines at once, reserved bits zero
    step('1, 1'b0, '0, 1'b0);
    check("R9 all bits latch", rd_data, 32'h0000_7FFF);
    check("R7 reserved zero", {17'b0, rd_data[31:15]}, '0);

    // R1: mid-run reset clears status, irq and mask
    step('0, 1'b1, 15'h0008, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 status after reset", rd_data, '0);
    check("R1 irq after reset", {31'b0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    step(15'h0008, 1'b0, '0, 1'b0);
    step('0, 1'b0, '0, 1'b0);
    check("R1 mask cleared by reset", {31'b0, irq}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule